// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block decides, every clock cycle, whether each channel of a two-channel isolated gate driver must be held in its safe state. The safe state means the output is pulled low and the switch is off. The block takes three kinds of input:

- a digitized sample of each channel's isolated supply voltage, each with its own valid strobe;
- a digitized junction-temperature sample with a valid strobe;
- a heartbeat pulse from the control-side link, together with a flag that reports whether the control-side supply is good.

For each channel the block raises a safe-state request. It also exposes its fault flags as registered outputs. Analog comparison, output clamping and input-pin decoding are handled elsewhere. The output stage simply gates its drive with the per-channel request.

Undervoltage and overtemperature each use two thresholds, so a noisy sample near one level cannot make the flag toggle. A supply that is still ramping up is treated as a fault until it reaches the upper release level. A link watchdog counts clock cycles since the last heartbeat and reports a lost control side. No fault is latched. Once every source has cleared, the request drops and the output again follows its inputs. Thresholds are parameters in ADC codes, and the watchdog limit is a parameter in clock cycles.

Top module: `drv_fault_sup`

## Requirements
- R1: After reset, every fault flag (`uv_flag`, `ot_flag`, `link_lost`, `ctl_lost`) is 1 and both bits of `safe_req` are 1. Flags clear only when the inputs meet their release conditions.
- R2: A set `uv_flag[i]` clears on the clock edge after a valid supply sample on channel i that is at or above `VS_ON_CODE` (default 364). A valid sample below that level leaves it set, including during power-up.
- R3: A clear `uv_flag[i]` sets on the clock edge after a valid sample below `VS_OFF_CODE` (default 336). A valid sample in the band [`VS_OFF_CODE`, `VS_ON_CODE`) leaves the flag unchanged in either state.
- R4: Each channel's undervoltage flag depends only on that channel's supply sample. Channel i uses bits [i*ADC_W +: ADC_W] of `vs_code` and bit i of `vs_vld`.
- R5: `ot_flag` sets on the clock edge after a valid temperature sample at or above `TJ_TRIP_CODE` (default 680). A higher code means a higher temperature.
- R6: A set `ot_flag` clears only on a valid temperature sample below `TJ_TRIP_CODE - TJ_HYST_CODE` (default 600). Valid samples in [600, 680) leave the flag unchanged.
- R7: A sample whose valid bit is 0 has no effect on any flag.
- R8: `link_lost` sets on the (`HB_TIMEOUT`+1)-th consecutive clock edge without a heartbeat (default `HB_TIMEOUT` 15). It clears on the edge at which `hb_pulse` is 1.
- R9: `ctl_lost` equals the inverse of `ctl_pwr_ok`, registered, with one cycle of delay.
- R10: `safe_req[i]` is 1 exactly when `uv_flag[i]`, `ot_flag`, `link_lost` or `ctl_lost` is 1. The shared sources therefore drive both channels.
- R11: No history is latched. When the last active fault source clears, `safe_req` drops in the same cycle as that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| vs_code | input | NCH*ADC_W | Per-channel isolated supply samples, channel i in slice i |
| vs_vld | input | NCH | Per-channel supply sample valid |
| tj_code | input | ADC_W | Junction temperature sample |
| tj_vld | input | 1 | Temperature sample valid |
| hb_pulse | input | 1 | Heartbeat from the control-side link |
| ctl_pwr_ok | input | 1 | Control-side supply good |
| safe_req | output | NCH | Per-channel safe-state request |
| uv_flag | output | NCH | Per-channel undervoltage flag |
| ot_flag | output | 1 | Overtemperature flag |
| link_lost | output | 1 | Heartbeat watchdog expired |
| ctl_lost | output | 1 | Control supply missing |

## Verification
The assertions check the per-cycle rules on every cycle:

- a valid sample below the trip level sets its flag, and one past the release level clears it;
- a sample in either hysteresis band or without its valid bit leaves the flag stable;
- a heartbeat clears the watchdog;
- no request is low while any source flag is high.

Some behaviours can only be shown by the bench scenarios:

- the exact number of idle cycles before the watchdog fires;
- the boundary codes at each threshold;
- the fact that one channel's undervoltage leaves the other channel free;
- the order of the power-up sequence from the all-faults reset state to a released output.

// File: rtl/drv_fault_sup_pkg.sv
package drv_fault_sup_pkg;

  // Where a sample lies relative to a monitor's two thresholds
  typedef enum logic [1:0] {
    BAND_HOLD  = 2'd0,
    BAND_TRIP  = 2'd1,
    BAND_CLEAR = 2'd2
  } band_e;

  // Which side of the scale is the faulty one
  typedef enum logic {
    FAULT_LOW  = 1'b0,
    FAULT_HIGH = 1'b1
  } fault_dir_e;

endpackage

// File: rtl/drv_rst_sync.sv
module drv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/drv_hyst_mon.sv
module drv_hyst_mon
  import drv_fault_sup_pkg::*;
#(
  parameter int         ADC_W     = 10,
  parameter int         TRIP_LVL  = 336,
  parameter int         CLEAR_LVL = 364,
  parameter fault_dir_e DIR       = FAULT_LOW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADC_W-1:0] smp,
  input  logic             smp_vld,
  output logic             flag
);
  localparam logic [ADC_W-1:0] TRIP_C  = ADC_W'(TRIP_LVL);
  localparam logic [ADC_W-1:0] CLEAR_C = ADC_W'(CLEAR_LVL);

  band_e band;
  logic  flag_d;
  logic  flag_en;

  generate
    if (DIR == FAULT_LOW) begin : g_low
      always_comb begin
        if (smp < TRIP_C)        band = BAND_TRIP;
        else if (smp >= CLEAR_C) band = BAND_CLEAR;
        else                     band = BAND_HOLD;
      end
    end else begin : g_high
      always_comb begin
        if (smp >= TRIP_C)      band = BAND_TRIP;
        else if (smp < CLEAR_C) band = BAND_CLEAR;
        else                    band = BAND_HOLD;
      end
    end
  endgenerate

  always_comb begin
    flag_d  = flag;
    flag_en = 1'b0;
    if (smp_vld) begin
      unique case (band)
        BAND_TRIP:  begin flag_d = 1'b1; flag_en = 1'b1; end
        BAND_CLEAR: begin flag_d = 1'b0; flag_en = 1'b1; end
        default:    begin flag_d = flag; flag_en = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b1;
    else if (flag_en) flag <= flag_d;
  end
endmodule

// File: rtl/drv_link_wdog.sv
module drv_link_wdog #(
  parameter int HB_TIMEOUT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_pulse,
  output logic lost
);
  localparam int CNT_W = $clog2(HB_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HB_TIMEOUT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lost_d;
  logic             at_limit;

  assign at_limit = (cnt_q == LIMIT);

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost;
    if (hb_pulse) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else if (at_limit) begin
      lost_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lost  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lost  <= lost_d;
    end
  end
endmodule

// File: rtl/drv_fault_sup.sv
module drv_fault_sup
  import drv_fault_sup_pkg::*;
#(
  parameter int NCH          = 2,
  parameter int ADC_W        = 10,
  parameter int VS_ON_CODE   = 364,
  parameter int VS_OFF_CODE  = 336,
  parameter int TJ_TRIP_CODE = 680,
  parameter int TJ_HYST_CODE = 80,
  parameter int HB_TIMEOUT   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH*ADC_W-1:0] vs_code,
  input  logic [NCH-1:0]     vs_vld,
  input  logic [ADC_W-1:0]   tj_code,
  input  logic               tj_vld,
  input  logic               hb_pulse,
  input  logic               ctl_pwr_ok,
  output logic [NCH-1:0]     safe_req,
  output logic [NCH-1:0]     uv_flag,
  output logic               ot_flag,
  output logic               link_lost,
  output logic               ctl_lost
);
  localparam int TJ_CLR_CODE = TJ_TRIP_CODE - TJ_HYST_CODE;

  logic rst_core_n;
  logic shared_fault;
  logic ctl_lost_d;

  drv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_uv
      drv_hyst_mon #(
        .ADC_W     (ADC_W),
        .TRIP_LVL  (VS_OFF_CODE),
        .CLEAR_LVL (VS_ON_CODE),
        .DIR       (FAULT_LOW)
      ) u_uv (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .smp     (vs_code[i*ADC_W +: ADC_W]),
        .smp_vld (vs_vld[i]),
        .flag    (uv_flag[i])
      );
    end
  endgenerate

  drv_hyst_mon #(
    .ADC_W     (ADC_W),
    .TRIP_LVL  (TJ_TRIP_CODE),
    .CLEAR_LVL (TJ_CLR_CODE),
    .DIR       (FAULT_HIGH)
  ) u_ot (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .smp     (tj_code),
    .smp_vld (tj_vld),
    .flag    (ot_flag)
  );

  drv_link_wdog #(.HB_TIMEOUT(HB_TIMEOUT)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .hb_pulse (hb_pulse),
    .lost     (link_lost)
  );

  assign ctl_lost_d = ~ctl_pwr_ok;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ctl_lost <= 1'b1;
    else             ctl_lost <= ctl_lost_d;
  end

  assign shared_fault = ot_flag | link_lost | ctl_lost;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      safe_req[i] = uv_flag[i] | shared_fault;
    end
  end
endmodule

// File: rtl/drv_fault_sup_chk.sv
module drv_fault_sup_chk #(
  parameter int NCH          = 2,
  parameter int ADC_W        = 10,
  parameter int VS_ON_CODE   = 364,
  parameter int VS_OFF_CODE  = 336,
  parameter int TJ_TRIP_CODE = 680,
  parameter int TJ_HYST_CODE = 80
) (
  input logic                 clk,
  input logic                 rst_core_n,
  input logic [NCH*ADC_W-1:0] vs_code,
  input logic [NCH-1:0]       vs_vld,
  input logic [ADC_W-1:0]     tj_code,
  input logic                 tj_vld,
  input logic                 hb_pulse,
  input logic [NCH-1:0]       safe_req,
  input logic [NCH-1:0]       uv_flag,
  input logic                 ot_flag,
  input logic                 link_lost,
  input logic                 ctl_lost
);
  localparam logic [ADC_W-1:0] ON_C   = ADC_W'(VS_ON_CODE);
  localparam logic [ADC_W-1:0] OFF_C  = ADC_W'(VS_OFF_CODE);
  localparam logic [ADC_W-1:0] TRIP_C = ADC_W'(TJ_TRIP_CODE);
  localparam logic [ADC_W-1:0] CLR_C  = ADC_W'(TJ_TRIP_CODE - TJ_HYST_CODE);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      AST_UV_RELEASE: assert property (@(posedge clk) disable iff (!rst_core_n)
        (vs_vld[i] && vs_code[i*ADC_W +: ADC_W] >= ON_C) |=> !uv_flag[i]); // R2
      AST_UV_TRIP: assert property (@(posedge clk) disable iff (!rst_core_n)
        (vs_vld[i] && vs_code[i*ADC_W +: ADC_W] < OFF_C) |=> uv_flag[i]); // R3
      AST_UV_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
        (vs_vld[i] && vs_code[i*ADC_W +: ADC_W] >= OFF_C && vs_code[i*ADC_W +: ADC_W] < ON_C)
        |=> $stable(uv_flag[i])); // R3
      AST_UV_NO_VALID: assert property (@(posedge clk) disable iff (!rst_core_n)
        !vs_vld[i] |=> $stable(uv_flag[i])); // R7
      AST_SAFE_COVERS: assert property (@(posedge clk) disable iff (!rst_core_n)
        !safe_req[i] |-> !(uv_flag[i] || ot_flag || link_lost || ctl_lost)); // R10
    end
  endgenerate

  AST_OT_TRIP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tj_vld && tj_code >= TRIP_C) |=> ot_flag); // R5
  AST_OT_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tj_vld && tj_code >= CLR_C && tj_code < TRIP_C) |=> $stable(ot_flag)); // R6
  AST_OT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_core_n)
    !tj_vld |=> $stable(ot_flag)); // R7
  AST_HB_CLEARS: assert property (@(posedge clk) disable iff (!rst_core_n)
    hb_pulse |=> !link_lost); // R8
  AST_LINK_ONLY_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(link_lost) |-> !$past(hb_pulse)); // R8
endmodule

bind drv_fault_sup drv_fault_sup_chk #(
  .NCH          (NCH),
  .ADC_W        (ADC_W),
  .VS_ON_CODE   (VS_ON_CODE),
  .VS_OFF_CODE  (VS_OFF_CODE),
  .TJ_TRIP_CODE (TJ_TRIP_CODE),
  .TJ_HYST_CODE (TJ_HYST_CODE)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .vs_code    (vs_code),
  .vs_vld     (vs_vld),
  .tj_code    (tj_code),
  .tj_vld     (tj_vld),
  .hb_pulse   (hb_pulse),
  .safe_req   (safe_req),
  .uv_flag    (uv_flag),
  .ot_flag    (ot_flag),
  .link_lost  (link_lost),
  .ctl_lost   (ctl_lost)
);

// File: tb/drv_fault_sup_test.sv
module drv_fault_sup_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int ADC_W = 10;
  localparam int HB_TIMEOUT = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH*ADC_W-1:0] vs_code = '0;
  logic [NCH-1:0] vs_vld = '0;
  logic [ADC_W-1:0] tj_code = '0;
  logic tj_vld = 1'b0;
  logic hb_gen = 1'b0;
  logic hb_man = 1'b0;
  logic hb_en = 1'b0;
  logic ctl_pwr_ok = 1'b0;
  logic hb_pulse;
  logic [NCH-1:0] safe_req, uv_flag;
  logic ot_flag, link_lost, ctl_lost;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign hb_pulse = hb_gen | hb_man;

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_fault_sup #(.NCH(NCH), .ADC_W(ADC_W), .HB_TIMEOUT(HB_TIMEOUT)) uut (
    .clk(clk), .rst_n(rst_n), .vs_code(vs_code), .vs_vld(vs_vld),
    .tj_code(tj_code), .tj_vld(tj_vld), .hb_pulse(hb_pulse),
    .ctl_pwr_ok(ctl_pwr_ok), .safe_req(safe_req), .uv_flag(uv_flag),
    .ot_flag(ot_flag), .link_lost(link_lost), .ctl_lost(ctl_lost)
  );

  // Heartbeat every 8 cycles while enabled
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      hb_gen = hb_en && (k % 8 == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Apply one supply sample on channel ch for one edge; return at next negedge
  task automatic vs_sample(input int ch, input int code);
    vs_code[ch*ADC_W +: ADC_W] = ADC_W'(code);
    vs_vld[ch] = 1'b1;
    @(negedge clk);
    vs_vld[ch] = 1'b0;
  endtask

  task automatic tj_sample(input int code);
    tj_code = ADC_W'(code);
    tj_vld = 1'b1;
    @(negedge clk);
    tj_vld = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 uv_flag in reset", int'(uv_flag), 3);
    check("R1 safe_req in reset", int'(safe_req), 3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 flags after reset", int'({ot_flag, link_lost, ctl_lost}), 7);
    check("R1 uv_flag after reset", int'(uv_flag), 3);
  endtask

  task automatic t_bringup;
    ctl_pwr_ok = 1'b1;
    hb_en = 1'b1;
    tj_sample(300);
    check("R6 ot clears on cold sample", int'(ot_flag), 0);
    vs_sample(0, 200);
    check("R2 ramp low keeps uv", int'(uv_flag[0]), 1);
    vs_sample(0, 363);
    check("R2 one below on-level keeps uv", int'(uv_flag[0]), 1);
    vs_sample(0, 364);
    check("R2 on-level releases ch0", int'(uv_flag[0]), 0);
    check("R4 ch1 still in lockout", int'(uv_flag[1]), 1);
    vs_sample(1, 400);
    repeat (10) @(negedge clk);
    check("R9 ctl_lost cleared", int'(ctl_lost), 0);
    check("R8 link up with heartbeats", int'(link_lost), 0);
    check("R11 safe_req released", int'(safe_req), 0);
  endtask

  task automatic t_uv_hyst;
    vs_sample(0, 340);
    check("R3 band keeps clear flag", int'(uv_flag[0]), 0);
    vs_sample(0, 336);
    check("R3 off-level keeps clear flag", int'(uv_flag[0]), 0);
    vs_sample(0, 335);
    check("R3 below off-level trips", int'(uv_flag[0]), 1);
    check("R4 ch1 unaffected", int'(uv_flag[1]), 0);
    check("R10 only ch0 safe", int'(safe_req), 1);
    vs_sample(0, 350);
    check("R3 band keeps set flag", int'(uv_flag[0]), 1);
    vs_sample(0, 364);
    check("R11 ch0 released", int'(safe_req), 0);
  endtask

  task automatic t_valid;
    vs_code[0 +: ADC_W] = ADC_W'(50);
    tj_code = ADC_W'(900);
    repeat (3) @(negedge clk);
    check("R7 supply without valid ignored", int'(uv_flag), 0);
    check("R7 temp without valid ignored", int'(ot_flag), 0);
    check("R7 safe_req unchanged", int'(safe_req), 0);
  endtask

  task automatic t_ot;
    tj_sample(679);
    check("R5 below trip stays clear", int'(ot_flag), 0);
    tj_sample(680);
    check("R5 trip code sets", int'(ot_flag), 1);
    check("R10 shared fault hits both", int'(safe_req), 3);
    tj_sample(620);
    check("R6 band keeps set", int'(ot_flag), 1);
    tj_sample(600);
    check("R6 clear level keeps set", int'(ot_flag), 1);
    tj_sample(599);
    check("R6 below clear level releases", int'(ot_flag), 0);
    check("R11 both released", int'(safe_req), 0);
  endtask

  task automatic t_wdog;
    hb_en = 1'b0;
    @(negedge clk);
    hb_man = 1'b1;
    @(negedge clk);
    hb_man = 1'b0;
    repeat (HB_TIMEOUT) @(negedge clk);
    check("R8 still alive at limit", int'(link_lost), 0);
    @(negedge clk);
    check("R8 lost after limit+1 idle edges", int'(link_lost), 1);
    check("R10 link loss safes both", int'(safe_req), 3);
    hb_man = 1'b1;
    @(negedge clk);
    hb_man = 1'b0;
    check("R8 heartbeat clears", int'(link_lost), 0);
    check("R11 released after heartbeat", int'(safe_req), 0);
    hb_en = 1'b1;
  endtask

  task automatic t_ctl;
    ctl_pwr_ok = 1'b0;
    @(negedge clk);
    check("R9 ctl_lost follows", int'(ctl_lost), 1);
    check("R10 ctl loss safes both", int'(safe_req), 3);
    ctl_pwr_ok = 1'b1;
    @(negedge clk);
    check("R9 ctl_lost clears", int'(ctl_lost), 0);
    check("R11 released", int'(safe_req), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_bringup();
    t_uv_hyst();
    t_valid();
    t_ot();
    t_wdog();
    t_ctl();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule